// File: doc/BRIEF.md
# Banked Internal Scratchpad Controller

This block holds the 256-byte on-chip scratchpad of an 8-bit microcontroller core and turns each request from the core into the right storage access, based on the addressing mode the core names. Register operands pick one of eight byte registers in one of four banks, and a two-bit bank selector from the core's status word chooses the bank. Direct accesses in the lower half reach the RAM. Direct accesses in the upper half go out on a request/response port to the special-register space. Indirect accesses take their pointer from pointer register 0 or 1 of the active bank and always reach RAM, including the upper 128 bytes.

A bit mode addresses 128 single bits laid over sixteen bytes starting at 0x20. Push and pop use a stack pointer kept inside the block, which starts at 0x07 after reset. Every RAM request is accepted at once and answered one cycle later. A special-register request holds the block busy until the far side signals ready.

Top module: `iram_bank_ctrl`

## Requirements
- R1: After reset the stack pointer reads 0x07, `req_ready` is 1, `rsp_valid` and `sfr_req` are 0, and every scratchpad byte reads 0x00.
- R2: In register mode (`req_mode`=0) the operand `req_addr[2:0]` reaches byte address {3'b000, bank_sel[1:0], req_addr[2:0]}, so register 3 of bank 2 is byte 0x13.
- R3: In direct mode (`req_mode`=1) addresses 0x00–0x7F read and write RAM. Addresses 0x80–0xFF raise `sfr_req` with the address, write data and write enable, and leave RAM untouched.
- R4: In indirect mode (`req_mode`=2) the pointer is the byte in register {bank_sel, 2'b00, req_addr[0]}. The access always reaches RAM, also for pointers 0x80–0xFF, and never raises `sfr_req`.
- R5: In bit mode (`req_mode`=3) bit address b (`req_addr[6:0]`) selects bit b[2:0] of byte 0x20+b[6:3]. A read returns that bit in `rsp_rdata[0]` with bits 7:1 zero.
- R6: A bit write stores `req_wdata[0]` into the selected bit and leaves the other seven bits of that byte unchanged, within the single request cycle.
- R7: A push (`req_mode`=4) writes `req_wdata` to byte SP+1 and then sets SP to SP+1, so the first push after reset lands at 0x08.
- R8: A pop (`req_mode`=5) returns the byte at SP and then sets SP to SP-1. The pointer wraps modulo 256 in both directions.
- R9: A RAM request is accepted in the cycle it is presented with `req_ready` high. `rsp_valid` is high for exactly the following cycle, and `req_ready` stays high.
- R10: During a special-register request `sfr_req` and its address, data and write enable hold steady and `req_ready` is 0 until `sfr_ready`. Requests presented meanwhile are ignored. `rsp_valid` comes with `sfr_rdata` in the cycle after the ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 3 | 0 reg, 1 direct, 2 indirect, 3 bit, 4 push, 5 pop |
| req_we | input | 1 | Write for reg/direct/indirect/bit modes |
| req_addr | input | 8 | Register number, address, pointer select or bit address |
| req_wdata | input | 8 | Write byte; bit writes use bit 0 |
| bank_sel | input | 2 | Active register bank from the status word |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 8 | Read data |
| stk_ptr | output | 8 | Current stack pointer |
| sfr_req | output | 1 | Special-register request pending |
| sfr_we | output | 1 | Special-register write |
| sfr_addr | output | 8 | Special-register address |
| sfr_wdata | output | 8 | Special-register write data |
| sfr_ready | input | 1 | Special-register side completes |
| sfr_rdata | input | 8 | Special-register read data |

## Verification
A RAM request presented before a rising edge gives `rsp_valid` and data after that edge. The stack pointer and stored bytes change at that same edge. So the bench drives on the falling edge, lets one rising edge pass, and samples on the next falling edge. A special-register request shows `sfr_req` one edge after acceptance and answers one edge after the cycle in which `sfr_ready` is high. The bench samples the held fields, a request presented while busy, and the response each at its own falling edge. Results that have no output of their own are read back through later direct, indirect or bit reads.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int IRAM_AW = 8;
  localparam int IRAM_DW = 8;

  typedef enum logic [2:0] {
    AM_REG  = 3'd0,
    AM_DIR  = 3'd1,
    AM_IND  = 3'd2,
    AM_BIT  = 3'd3,
    AM_PUSH = 3'd4,
    AM_POP  = 3'd5
  } acc_mode_e;

  // byte address of register r in bank b
  function automatic logic [7:0] reg_slot(input logic [1:0] b, input logic [2:0] r);
    return {3'b000, b, r};
  endfunction

  // byte holding bit address ba
  function automatic logic [7:0] bit_home(input logic [6:0] ba);
    return 8'h20 + {4'b0000, ba[6:3]};
  endfunction

  function automatic logic [7:0] bit_mask(input logic [2:0] pos);
    return 8'h01 << pos;
  endfunction

  function automatic logic [7:0] merge_bits(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic [7:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
#(
  parameter int AW = IRAM_AW
) (
  input  logic [2:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    bank,
  input  logic [AW-1:0] ptr_val,
  input  logic [AW-1:0] sp,
  output logic [AW-1:0] ptr_addr,
  output logic [AW-1:0] eff_addr,
  output logic          to_sfr,
  output logic          bit_op,
  output logic [2:0]    bit_pos
);
  acc_mode_e m;
  assign m        = acc_mode_e'(mode);
  assign ptr_addr = reg_slot(bank, {2'b00, addr[0]});
  assign bit_pos  = addr[2:0];

  always_comb begin
    eff_addr = addr;
    to_sfr   = 1'b0;
    bit_op   = 1'b0;
    unique case (m)
      AM_REG:  eff_addr = reg_slot(bank, addr[2:0]);
      AM_DIR:  to_sfr   = addr[AW-1];
      AM_IND:  eff_addr = ptr_val;
      AM_BIT:  begin eff_addr = bit_home(addr[6:0]); bit_op = 1'b1; end
      AM_PUSH: eff_addr = sp + 1'b1;
      AM_POP:  eff_addr = sp;
      default: eff_addr = addr;
    endcase
  end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_mask,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] wr_old;

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
  assign wr_old    = mem[wr_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= (wr_old & ~wr_mask) | (wr_data & wr_mask);
    end
  end

  // R6
  keep_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((mem[$past(wr_addr)] ^ $past(wr_old)) & ~$past(wr_mask)) == '0));
  // R6
  write_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem[$past(wr_addr)] & $past(wr_mask)) == ($past(wr_data) & $past(wr_mask))));
endmodule

// File: rtl/iram_stack.sv
module iram_stack #(
  parameter int            AW     = 8,
  parameter logic [AW-1:0] RST_SP = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] sp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp <= RST_SP;
    else if (push) sp <= sp + 1'b1;
    else if (pop)  sp <= sp - 1'b1;
  end

  // R7
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp == AW'($past(sp) + 1));
  // R8
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push |=> sp == AW'($past(sp) - 1));
endmodule

// File: rtl/iram_sfr_port.sv
module iram_sfr_port #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          we_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] done_data,
  output logic          sfr_req,
  output logic          sfr_we,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic          sfr_ready,
  input  logic [DW-1:0] sfr_rdata
);
  logic finish;
  assign busy    = sfr_req;
  assign finish  = sfr_req && sfr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sfr_req   <= 1'b0;
      sfr_we    <= 1'b0;
      sfr_addr  <= '0;
      sfr_wdata <= '0;
      done      <= 1'b0;
      done_data <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        sfr_req   <= 1'b0;
        done_data <= sfr_rdata;
      end else if (start && !sfr_req) begin
        sfr_req   <= 1'b1;
        sfr_we    <= we_in;
        sfr_addr  <= addr_in;
        sfr_wdata <= wdata_in;
      end
    end
  end

  // R10
  sfr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_req && !sfr_ready |=> sfr_req && $stable(sfr_addr) && $stable(sfr_we) && $stable(sfr_wdata));
  // R10
  sfr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_req && sfr_ready |=> done && !sfr_req);
endmodule

// File: rtl/iram_bank_ctrl.sv
module iram_bank_ctrl
  import iram_pkg::*;
#(
  parameter int              AW     = IRAM_AW,
  parameter int              DW     = IRAM_DW,
  parameter logic [AW-1:0]   RST_SP = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_mode,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    bank_sel,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] stk_ptr,
  output logic          sfr_req,
  output logic          sfr_we,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic          sfr_ready,
  input  logic [DW-1:0] sfr_rdata
);
  logic [AW-1:0] ptr_addr, eff_addr;
  logic [DW-1:0] ptr_val, cur_byte;
  logic          to_sfr, bit_op, sfr_busy, sfr_done;
  logic [2:0]    bit_pos;
  logic [DW-1:0] sfr_data;

  // named events
  logic accept, ram_acc, sfr_start, do_push, do_pop, wr_en;
  logic [DW-1:0] wr_mask, wr_data;

  assign req_ready = !sfr_busy;
  assign accept    = req_valid && req_ready;
  assign ram_acc   = accept && !to_sfr;
  assign sfr_start = accept && to_sfr;
  assign do_push   = ram_acc && (req_mode == AM_PUSH);
  assign do_pop    = ram_acc && (req_mode == AM_POP);
  assign wr_en     = ram_acc && !do_pop && (req_we || do_push);
  assign wr_mask   = bit_op ? bit_mask(bit_pos) : '1;
  assign wr_data   = bit_op ? {DW{req_wdata[0]}} : req_wdata;

  iram_addr_map #(.AW(AW)) u_map (
    .mode(req_mode), .addr(req_addr), .bank(bank_sel), .ptr_val(ptr_val),
    .sp(stk_ptr), .ptr_addr(ptr_addr), .eff_addr(eff_addr),
    .to_sfr(to_sfr), .bit_op(bit_op), .bit_pos(bit_pos)
  );

  iram_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(ptr_addr), .rd_a_data(ptr_val),
    .rd_b_addr(eff_addr), .rd_b_data(cur_byte),
    .wr_en(wr_en), .wr_addr(eff_addr), .wr_mask(wr_mask), .wr_data(wr_data)
  );

  iram_stack #(.AW(AW), .RST_SP(RST_SP)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop), .sp(stk_ptr)
  );

  iram_sfr_port #(.AW(AW), .DW(DW)) u_sfr (
    .clk(clk), .rst_n(rst_n), .start(sfr_start), .we_in(req_we),
    .addr_in(req_addr), .wdata_in(req_wdata), .busy(sfr_busy),
    .done(sfr_done), .done_data(sfr_data),
    .sfr_req(sfr_req), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_ready(sfr_ready), .sfr_rdata(sfr_rdata)
  );

  logic          ram_rsp_q;
  logic [DW-1:0] ram_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_rsp_q  <= 1'b0;
      ram_data_q <= '0;
    end else begin
      ram_rsp_q <= ram_acc;
      if (ram_acc)
        ram_data_q <= bit_op ? {{(DW-1){1'b0}}, cur_byte[bit_pos]} : cur_byte;
    end
  end

  assign rsp_valid = ram_rsp_q | sfr_done;
  assign rsp_rdata = sfr_done ? sfr_data : ram_data_q;

  // R9
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(sfr_ready)));
  // R10
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_req |-> !req_ready);
  // R4
  ind_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == AM_IND) |=> !sfr_req);
  // R3
  dir_low_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == AM_DIR && !req_addr[AW-1]) |=> !sfr_req);
endmodule

// File: tb/iram_bank_ctrl_tb.sv
`timescale 1ns/1ps
module iram_bank_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_we = 1'b0;
  logic [2:0] req_mode = '0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic [1:0] bank_sel = '0;
  logic       sfr_ready = 1'b0;
  logic [7:0] sfr_rdata = '0;
  logic       req_ready, rsp_valid, sfr_req, sfr_we;
  logic [7:0] rsp_rdata, stk_ptr, sfr_addr, sfr_wdata;

  int total = 0, bad = 0;
  bit finished = 0;

  localparam logic [2:0] M_REG = 0, M_DIR = 1, M_IND = 2, M_BIT = 3, M_PUSH = 4, M_POP = 5;

  always #2.5 clk = ~clk;

  iram_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_sel(bank_sel), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .stk_ptr(stk_ptr),
    .sfr_req(sfr_req), .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_ready(sfr_ready), .sfr_rdata(sfr_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // present one request at a falling edge; return at the falling edge after acceptance
  task automatic issue(input logic [2:0] m, input logic we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ready", {7'b0, req_ready}, 8'h01);
    chk("R1 rsp_valid", {7'b0, rsp_valid}, 8'h00);
    chk("R1 sfr_req", {7'b0, sfr_req}, 8'h00);
    chk("R1 sp", stk_ptr, 8'h07);
    issue(M_DIR, 0, 8'h10, 8'h00);
    chk("R1 ram zero", rsp_rdata, 8'h00);
  endtask

  task automatic t_latency();
    issue(M_DIR, 0, 8'h11, 8'h00);
    chk("R9 rsp after accept", {7'b0, rsp_valid}, 8'h01);
    chk("R9 ready held", {7'b0, req_ready}, 8'h01);
    @(negedge clk);
    chk("R9 rsp one cycle", {7'b0, rsp_valid}, 8'h00);
  endtask

  task automatic t_regbank();
    bank_sel = 2'd2;
    issue(M_REG, 1, 8'h03, 8'hA3);
    bank_sel = 2'd0;
    issue(M_REG, 0, 8'h03, 8'h00);
    chk("R2 other bank untouched", rsp_rdata, 8'h00);
    issue(M_DIR, 0, 8'h13, 8'h00);
    chk("R2 bank2 r3 at 0x13", rsp_rdata, 8'hA3);
    issue(M_DIR, 1, 8'h55, 8'h3E);
    issue(M_DIR, 0, 8'h55, 8'h00);
    chk("R3 direct low ram", rsp_rdata, 8'h3E);
  endtask

  task automatic t_indirect();
    bank_sel = 2'd1;
    issue(M_REG, 1, 8'h01, 8'h90);
    issue(M_IND, 1, 8'h01, 8'h3C);
    chk("R4 no sfr for upper ind", {7'b0, sfr_req}, 8'h00);
    issue(M_IND, 0, 8'h01, 8'h00);
    chk("R4 upper ram via r1", rsp_rdata, 8'h3C);
    issue(M_REG, 1, 8'h00, 8'h40);
    issue(M_IND, 1, 8'h00, 8'h77);
    issue(M_DIR, 0, 8'h40, 8'h00);
    chk("R4 low ram via r0", rsp_rdata, 8'h77);
    bank_sel = 2'd0;
  endtask

  task automatic t_bits();
    issue(M_BIT, 1, 8'h13, 8'h01);
    issue(M_DIR, 0, 8'h22, 8'h00);
    chk("R5 bit 0x13 is byte 0x22 bit3", rsp_rdata, 8'h08);
    issue(M_BIT, 0, 8'h13, 8'h00);
    chk("R5 bit read set", rsp_rdata, 8'h01);
    issue(M_BIT, 0, 8'h12, 8'h00);
    chk("R5 bit read clear", rsp_rdata, 8'h00);
    issue(M_DIR, 1, 8'h2F, 8'hFF);
    issue(M_BIT, 1, 8'h7C, 8'hFE);
    issue(M_DIR, 0, 8'h2F, 8'h00);
    chk("R6 clear one bit", rsp_rdata, 8'hEF);
    issue(M_DIR, 1, 8'h25, 8'h5A);
    issue(M_BIT, 1, 8'h28, 8'h01);
    issue(M_DIR, 0, 8'h25, 8'h00);
    chk("R6 set one bit", rsp_rdata, 8'h5B);
  endtask

  task automatic t_stack();
    chk("R7 sp start", stk_ptr, 8'h07);
    issue(M_PUSH, 0, 8'h00, 8'h11);
    chk("R7 sp inc", stk_ptr, 8'h08);
    issue(M_PUSH, 0, 8'h00, 8'h22);
    issue(M_DIR, 0, 8'h08, 8'h00);
    chk("R7 first push at 0x08", rsp_rdata, 8'h11);
    issue(M_POP, 0, 8'h00, 8'h00);
    chk("R8 pop data", rsp_rdata, 8'h22);
    chk("R8 sp dec", stk_ptr, 8'h08);
    issue(M_POP, 0, 8'h00, 8'h00);
    chk("R8 pop data 2", rsp_rdata, 8'h11);
    chk("R8 sp back", stk_ptr, 8'h07);
  endtask

  task automatic t_wrap();
    issue(M_DIR, 1, 8'h00, 8'h5E);
    for (int i = 0; i < 7; i++) issue(M_POP, 0, 8'h00, 8'h00);
    chk("R8 sp at zero", stk_ptr, 8'h00);
    issue(M_POP, 0, 8'h00, 8'h00);
    chk("R8 pop at zero data", rsp_rdata, 8'h5E);
    chk("R8 sp wraps down", stk_ptr, 8'hFF);
    issue(M_PUSH, 0, 8'h00, 8'h6D);
    chk("R8 sp wraps up", stk_ptr, 8'h00);
    issue(M_DIR, 0, 8'h00, 8'h00);
    chk("R7 push after wrap at 0x00", rsp_rdata, 8'h6D);
  endtask

  task automatic t_sfr();
    issue(M_DIR, 1, 8'h85, 8'hC4);
    chk("R3 sfr_req", {7'b0, sfr_req}, 8'h01);
    chk("R3 sfr_addr", sfr_addr, 8'h85);
    chk("R3 sfr_we", {7'b0, sfr_we}, 8'h01);
    chk("R3 sfr_wdata", sfr_wdata, 8'hC4);
    chk("R10 ready low", {7'b0, req_ready}, 8'h00);
    chk("R10 no rsp yet", {7'b0, rsp_valid}, 8'h00);
    req_valid = 1'b1; req_mode = M_DIR; req_we = 1'b1; req_addr = 8'h30; req_wdata = 8'h99;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    chk("R10 addr held", sfr_addr, 8'h85);
    chk("R10 still pending", {7'b0, sfr_req}, 8'h01);
    sfr_ready = 1'b1; sfr_rdata = 8'h00;
    @(negedge clk);
    sfr_ready = 1'b0;
    chk("R10 rsp after ready", {7'b0, rsp_valid}, 8'h01);
    chk("R10 req dropped", {7'b0, sfr_req}, 8'h00);
    chk("R10 ready again", {7'b0, req_ready}, 8'h01);
    issue(M_DIR, 0, 8'h30, 8'h00);
    chk("R10 busy request ignored", rsp_rdata, 8'h00);
    issue(M_REG, 1, 8'h00, 8'h85);
    issue(M_IND, 0, 8'h00, 8'h00);
    chk("R3 sfr write kept out of ram", rsp_rdata, 8'h00);
    issue(M_DIR, 0, 8'hF0, 8'h00);
    chk("R3 sfr read we", {7'b0, sfr_we}, 8'h00);
    sfr_ready = 1'b1; sfr_rdata = 8'hB7;
    @(negedge clk);
    sfr_ready = 1'b0;
    chk("R10 sfr read valid", {7'b0, rsp_valid}, 8'h01);
    chk("R10 sfr read data", rsp_rdata, 8'hB7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_regbank();
    t_indirect();
    t_bits();
    t_stack();
    t_wrap();
    t_sfr();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule